// File: doc/BRIEF.md
# Track Switch Coil Pulse Controller

This block fires the two solenoid coils of a bank of track switches. Each switch is a point with two coils: one pulls it to the straight route and one pulls it to the diverging route. A supervisor writes a position word, one bit per switch, and raises a load strobe. For each switch whose requested bit differs from the position it last applied, the block energises the coil for the new route for a fixed number of clock cycles. It then drops the coil, even while the request is still held.

Every coil has its own output line toward the power stage. The block keeps a per-switch watchdog that cuts drive before the coil has been on for the 50 ms cap. It also guarantees that the two coils of one switch are never on together. A request that arrives while a switch is pulsing, or in the single dead cycle after a pulse, is held. It is served after that dead cycle if it still asks for a move.

Top module: `switch_coil_pulser`

## Requirements
- R1: When `cmd_load` is high on a clock edge and a switch is idle and its bit in `cmd_pos` differs from its applied position, a pulse begins in the next cycle. The pulse appears on `coil_div` for a requested 1 and on `coil_norm` for a requested 0, and the applied position takes the new value.
- R2: A pulse lasts exactly `PULSE_CYC` cycles. The coil then goes low whatever the inputs do.
- R3: A load whose bit equals the applied position of an idle switch is ignored: no coil and no busy for that switch.
- R4: `coil_norm[i]` and `coil_div[i]` are never high in the same cycle.
- R5: A coil is never on for `CLK_HZ/1000*CAP_MS` cycles or more. A per-switch on-time counter forces the coil off, and elaboration rejects a `PULSE_CYC` that is not below this limit.
- R6: `busy[i]` is high for every pulse cycle and for exactly one dead cycle after it, with both coils low in that dead cycle.
- R7: A load seen while a switch is busy is latched, and the last one wins. At the end of the dead cycle the switch pulses toward the latched bit if that bit differs from the applied position. Otherwise the latched bit is dropped and the switch goes idle.
- R8: Reset (active low, asynchronous) forces every coil and busy output low at once and sets every applied position to 0.
- R9: Switches act independently: several may pulse in the same cycles, each from its own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_pos | input | N_SW | Requested position per switch, 1 = diverging, 0 = straight |
| cmd_load | input | 1 | Strobe: sample `cmd_pos` on this edge |
| coil_norm | output | N_SW | Drive for the straight-route coil of each switch |
| coil_div | output | N_SW | Drive for the diverging-route coil of each switch |
| busy | output | N_SW | Switch is pulsing or in its dead cycle |

## Verification
The bench measures the exact pulse length and the single dead cycle. A design off by one in the counter would show a pulse one cycle too long or too short, or would restart with no gap. It repeats a position that is already applied, which a design comparing against the request instead of the applied position would pulse again. It sends loads during a pulse and during the dead cycle, including a pair that cancels out. A design that dropped the queued load, kept the first one instead of the last, or re-fired an unneeded move is caught there. A reset in the middle of a pulse must cut the coil at once and clear the stored positions, which a following all-zero load exposes.

// File: rtl/switch_coil_pulser.sv
module switch_coil_pulser #(
  parameter int N_SW      = 8,
  parameter int CLK_HZ    = 250_000_000,
  parameter int CAP_MS    = 50,
  parameter int PULSE_CYC = 5_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_SW-1:0] cmd_pos,
  input  logic            cmd_load,
  output logic [N_SW-1:0] coil_norm,
  output logic [N_SW-1:0] coil_div,
  output logic [N_SW-1:0] busy
);

  localparam int WD_LIM = CLK_HZ / 1000 * CAP_MS;
  localparam int CW     = $clog2(WD_LIM + 1);
  localparam logic [CW-1:0] LEN_M1 = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] WD_M1  = CW'(WD_LIM - 1);

  typedef enum logic [1:0] {SW_IDLE, SW_PULSE, SW_DEAD} sw_st_e;

  if (PULSE_CYC < 1 || PULSE_CYC >= WD_LIM) begin : g_bad_len
    $error("PULSE_CYC must be at least 1 and below the on-time cap");
  end

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    sw_st_e        st;
    logic          pos, pend_v, pend_val;
    logic [CW-1:0] cnt, on_cnt;
    logic          drive, wd_trip, want_v, want;

    assign want_v  = cmd_load | pend_v;
    assign want    = cmd_load ? cmd_pos[i] : pend_val;
    assign wd_trip = on_cnt >= WD_M1;
    assign drive   = (st == SW_PULSE) && !wd_trip;

    assign coil_div[i]  = drive &  pos;
    assign coil_norm[i] = drive & ~pos;
    assign busy[i]      = st != SW_IDLE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st       <= SW_IDLE;
        pos      <= 1'b0;
        pend_v   <= 1'b0;
        pend_val <= 1'b0;
        cnt      <= '0;
      end else begin
        case (st)
          SW_IDLE: if (cmd_load && cmd_pos[i] != pos) begin
            st  <= SW_PULSE;
            pos <= cmd_pos[i];
            cnt <= LEN_M1;
          end
          SW_PULSE: begin
            if (cmd_load) begin
              pend_v   <= 1'b1;
              pend_val <= cmd_pos[i];
            end
            if (cnt == '0 || wd_trip) st <= SW_DEAD;
            else cnt <= cnt - 1'b1;
          end
          SW_DEAD: begin
            pend_v <= 1'b0;
            if (want_v && want != pos) begin
              st  <= SW_PULSE;
              pos <= want;
              cnt <= LEN_M1;
            end else begin
              st <= SW_IDLE;
            end
          end
          default: st <= SW_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 on_cnt <= '0;
      else if (st == SW_PULSE)    on_cnt <= wd_trip ? on_cnt : on_cnt + 1'b1;
      else                        on_cnt <= '0;
    end

    logic [CW-1:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           chk_run <= '0;
      else if (coil_norm[i] || coil_div[i]) chk_run <= chk_run + 1'b1;
      else                                  chk_run <= '0;
    end

    a_r4_interlock: assert property (@(posedge clk) disable iff (!rst_n)
      !(coil_norm[i] && coil_div[i]));

    a_r2_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      chk_run <= CW'(PULSE_CYC));

    a_r3_ignore_same: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && !busy[i] && cmd_pos[i] == pos) |=> !busy[i]);

    a_r1_start_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && !busy[i] && cmd_pos[i] != pos) |=>
        (coil_div[i] == $past(cmd_pos[i])) && (coil_norm[i] != $past(cmd_pos[i])));

    a_r6_dead_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(coil_norm[i] || coil_div[i]) |-> busy[i]);
  end

endmodule

// File: tb/switch_coil_pulser_tb.sv
module switch_coil_pulser_tb;
  localparam int N  = 8;
  localparam int PL = 6;
  localparam int WD = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] cmd_pos = '0;
  logic         cmd_load = 1'b0;
  logic [N-1:0] coil_norm, coil_div, busy;

  int errors = 0;
  int checks = 0;
  int overlap = 0;
  int max_run = 0;
  int run [N];

  always #2 clk = ~clk;

  switch_coil_pulser #(.N_SW(N), .CLK_HZ(1000), .CAP_MS(WD), .PULSE_CYC(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_pos(cmd_pos), .cmd_load(cmd_load),
    .coil_norm(coil_norm), .coil_div(coil_div), .busy(busy));

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) run[i] = 0;
      else begin
        if (coil_norm[i] && coil_div[i]) overlap++;
        if (coil_norm[i] || coil_div[i]) run[i]++; else run[i] = 0;
        if (run[i] > max_run) max_run = run[i];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [N-1:0] v);
    @(negedge clk);
    cmd_pos  = v;
    cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic expect_pulse(input int idx, input bit dir);
    for (int k = 0; k < PL; k++) begin
      chk(coil_div[idx] == dir && coil_norm[idx] == !dir && busy[idx], "R2 pulse",
          {coil_div[idx], coil_norm[idx], busy[idx]}, {dir, !dir, 1'b1});
      @(negedge clk);
    end
  endtask

  task automatic expect_dead_then_idle(input int idx);
    chk(!coil_div[idx] && !coil_norm[idx] && busy[idx], "R6 dead cycle",
        {coil_div[idx], coil_norm[idx], busy[idx]}, 3'b001);
    @(negedge clk);
    chk(busy[idx] == 1'b0, "R6 idle after dead", busy[idx], 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(coil_norm == '0 && coil_div == '0 && busy == '0, "R8 reset outputs",
        {coil_norm, coil_div, busy}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_single;
    load(8'h01);
    chk(coil_div == 8'h01 && coil_norm == 8'h00, "R1 div start", {coil_div, coil_norm}, 16'h0100);
    expect_pulse(0, 1'b1);
    expect_dead_then_idle(0);
  endtask

  task automatic t_ignore;
    load(8'h01);
    chk(busy == '0 && coil_div == '0 && coil_norm == '0, "R3 same ignored",
        {busy, coil_div, coil_norm}, 0);
    @(negedge clk);
    chk(busy == '0, "R3 still idle", busy, 0);
  endtask

  task automatic t_back;
    load(8'h00);
    chk(coil_norm == 8'h01 && coil_div == 8'h00, "R1 norm start", {coil_div, coil_norm}, 16'h0001);
    expect_pulse(0, 1'b0);
    expect_dead_then_idle(0);
  endtask

  task automatic t_multi;
    load(8'hA5);
    for (int k = 0; k < PL; k++) begin
      chk(coil_div == 8'hA5 && coil_norm == 8'h00 && busy == 8'hA5, "R9 parallel pulse",
          {coil_div, coil_norm, busy}, 24'hA500A5);
      @(negedge clk);
    end
    chk(coil_div == '0 && busy == 8'hA5, "R6 parallel dead", {coil_div, busy}, 16'h00A5);
    @(negedge clk);
    chk(busy == '0, "R9 all idle", busy, 0);
  endtask

  task automatic t_queue;
    load(8'hA4);
    load(8'hA5);
    chk(coil_norm[0] && busy == 8'h01, "R7 pulse continues", {coil_norm[0], busy}, 9'h101);
    repeat (4) @(negedge clk);
    chk(!coil_norm[0] && !coil_div[0] && busy[0], "R7 dead before queued", busy[0], 1);
    @(negedge clk);
    expect_pulse(0, 1'b1);
    expect_dead_then_idle(0);
  endtask

  task automatic t_cancel;
    load(8'hA4);
    load(8'hA5);
    load(8'hA4);
    repeat (2) @(negedge clk);
    chk(busy[0] && !coil_norm[0], "R6 dead in cancel", busy[0], 1);
    @(negedge clk);
    chk(busy == '0 && coil_norm == '0 && coil_div == '0, "R7 last wins, dropped",
        {busy, coil_norm, coil_div}, 0);
  endtask

  task automatic t_dead_load;
    load(8'hA5);
    repeat (5) @(negedge clk);
    load(8'hA4);
    chk(coil_norm[0] && !coil_div[0], "R7 load in dead cycle", {coil_div[0], coil_norm[0]}, 1);
    expect_pulse(0, 1'b0);
    expect_dead_then_idle(0);
  endtask

  task automatic t_reset_mid;
    load(8'hA5);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(coil_div == '0 && coil_norm == '0 && busy == '0, "R8 async cut",
        {coil_div, coil_norm, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    load(8'h00);
    chk(busy == '0, "R8 positions cleared", busy, 0);
    load(8'h01);
    chk(coil_div == 8'h01, "R8 move from zero", coil_div, 1);
    repeat (PL + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) run[i] = 0;
    t_reset;
    t_single;
    t_ignore;
    t_back;
    t_multi;
    t_queue;
    t_cancel;
    t_dead_load;
    t_reset_mid;
    chk(overlap == 0, "R4 no coil overlap", overlap, 0);
    chk(max_run == PL, "R2 longest on-time", max_run, PL);
    chk(max_run < WD, "R5 below cap", max_run, WD);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule